// File: doc/BRIEF.md
# Polyphase Decimate-by-Four FIR Filter

This block low-pass filters a stream of signed 16-bit samples with a 16-tap FIR response and keeps one output for every four inputs. The filter is split into four sub-filters, each holding every fourth coefficient. A rotating input selector hands each accepted sample to exactly one sub-filter. When the fourth sample of a group has been routed, the four partial sums are added and one output word is produced. Outputs that decimation would discard are never computed.

A producer drives a sample together with a one-cycle valid flag. It may leave idle cycles between samples at will. The consumer receives a one-cycle output strobe with the filtered word. The word stays on the output bus until the next strobe. The coefficients are a design-time parameter. The output is the full-precision sum shifted right arithmetically by a parameterised amount and cut to a parameterised width.

Top module: `poly_decim_fir`

## Requirements
- R1: While `rst` is high on a clock edge, that edge clears every delay line, the selector phase, `out_valid` and `out_data`. The first cycle after reset shows `out_valid` = 0 and `out_data` = 0.
- R2: Samples are counted as 0, 1, 2, ... from reset. Sample t is accepted on an edge with `in_valid` = 1. For t mod 4 = 0, `out_valid` is high for exactly the one cycle after the edge that accepts sample t. In every other cycle it is low.
- R3: With default parameters the coefficients for taps 0..15 are -120, -300, 150, 980, 2300, 3700, 4900, 5600, 5500, 4800, 3600, 2200, 900, 100, -250, -90. The output at sample 4m is the convolution sum over i of h(i)·x(4m−i).
- R4: A cycle with `in_valid` = 0 changes no delay line and does not advance the selector phase, whatever value `in_data` carries. Gaps between samples therefore leave the output sequence unchanged.
- R5: Samples from before the last reset count as zero in the sum.
- R6: `out_data` is the full sum shifted right arithmetically by OUT_SHIFT = 15, keeping the low OUT_W = 20 bits. This rounds toward minus infinity, so a sum of −120 gives −1.
- R7: The accumulator is at least 36 bits wide. Full-scale inputs of −32768 and +32767 give exact results with no wrap.
- R8: Between strobes, `out_data` holds the last produced value.
- R9: A reset in the middle of a stream, after any number of samples, restarts phase counting at sample 0 and discards all history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on `in_data` this cycle |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a new output word |
| out_data | output | OUT_W (20) | Signed filtered and decimated output |

## Verification
Two small impulses tell different faults apart. An impulse of 1 shows the floor behaviour of the truncation, since a sum of −120 must appear as −1. An impulse of 16384 reads out the coefficients one decimated phase at a time, which exposes a swapped tap order or a wrong selector mapping. A constant step checks that all four sub-filters add together. Full-scale constants test the accumulator width. Random data with random idle gaps, and random `in_data` during those gaps, shows that invalid cycles are ignored. A reset in the middle of a stream, followed by a new impulse, shows that old history is gone and that phase counting starts again.

// File: rtl/poly_fir_pkg.sv
package poly_fir_pkg;

    // Width that holds the sum of n_terms full-scale signed products without wrap.
    function automatic int acc_width(input int data_w, input int coef_w, input int n_terms);
        return data_w + coef_w + $clog2(n_terms);
    endfunction

    // Width of the selector phase register (at least one bit).
    function automatic int phase_width(input int decim);
        return (decim > 1) ? $clog2(decim) : 1;
    endfunction

endpackage

// File: rtl/poly_commutator.sv
module poly_commutator #(
    parameter int DECIM = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic [DECIM-1:0] load_sel,
    output logic             group_end
);
    import poly_fir_pkg::*;

    localparam int PH_W = phase_width(DECIM);

    typedef struct packed {
        logic [PH_W-1:0] phase;
    } comm_st_t;

    comm_st_t st_d, st_q;

    always_comb begin
        int target;
        st_d     = st_q;
        load_sel = '0;
        // Sample with phase p feeds sub-filter (DECIM - p) mod DECIM.
        target   = (int'(st_q.phase) == 0) ? 0 : DECIM - int'(st_q.phase);
        for (int k = 0; k < DECIM; k++) begin
            load_sel[k] = in_valid && (k == target);
        end
        group_end = in_valid && (st_q.phase == '0);
        if (in_valid) begin
            if (int'(st_q.phase) == DECIM - 1) begin
                st_d.phase = '0;
            end else begin
                st_d.phase = st_q.phase + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/poly_subfilter.sv
module poly_subfilter #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int TAPS   = 4,
    parameter int ACC_W  = 36
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic [DATA_W-1:0]        sample,
    input  logic [TAPS*COEF_W-1:0]   coefs,
    output logic [ACC_W-1:0]         partial
);
    localparam int PROD_W = DATA_W + COEF_W;

    logic [DATA_W-1:0] line_d [TAPS];
    logic [DATA_W-1:0] line_q [TAPS];
    logic [PROD_W-1:0] prod   [TAPS];

    // Delay line moves only when this branch receives a sample.
    always_comb begin
        for (int j = 0; j < TAPS; j++) begin
            line_d[j] = line_q[j];
        end
        if (load) begin
            line_d[0] = sample;
            for (int j = 1; j < TAPS; j++) begin
                line_d[j] = line_q[j-1];
            end
        end
    end

    // Products use the updated line so the arriving sample counts at once.
    always_comb begin
        logic [ACC_W-1:0] acc;
        acc = '0;
        for (int j = 0; j < TAPS; j++) begin
            prod[j] = PROD_W'($signed(line_d[j]) * $signed(coefs[j*COEF_W +: COEF_W]));
            acc     = acc + {{(ACC_W-PROD_W){prod[j][PROD_W-1]}}, prod[j]};
        end
        partial = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TAPS; j++) begin
                line_q[j] <= '0;
            end
        end else begin
            for (int j = 0; j < TAPS; j++) begin
                line_q[j] <= line_d[j];
            end
        end
    end

endmodule

// File: rtl/poly_sum.sv
module poly_sum #(
    parameter int NUM       = 4,
    parameter int ACC_W     = 36,
    parameter int OUT_W     = 20,
    parameter int OUT_SHIFT = 15
) (
    input  logic [NUM*ACC_W-1:0] partials,
    output logic [OUT_W-1:0]     result
);
    always_comb begin
        logic signed [ACC_W-1:0] total;
        logic signed [ACC_W-1:0] scaled;
        total = '0;
        for (int k = 0; k < NUM; k++) begin
            total = total + $signed(partials[k*ACC_W +: ACC_W]);
        end
        scaled = total >>> OUT_SHIFT;
        result = scaled[OUT_W-1:0];
    end

endmodule

// File: rtl/poly_decim_fir.sv
module poly_decim_fir #(
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int NUM_TAPS  = 16,
    parameter int DECIM     = 4,
    parameter int OUT_W     = 20,
    parameter int OUT_SHIFT = 15,
    // Tap i sits at bits [i*COEF_W +: COEF_W].
    parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = {
        -16'sd90,   -16'sd250,  16'sd100,   16'sd900,
         16'sd2200,  16'sd3600, 16'sd4800,  16'sd5500,
         16'sd5600,  16'sd4900, 16'sd3700,  16'sd2300,
         16'sd980,   16'sd150,  -16'sd300,  -16'sd120
    }
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);
    import poly_fir_pkg::*;

    localparam int SUB_TAPS = NUM_TAPS / DECIM;
    localparam int ACC_W    = acc_width(DATA_W, COEF_W, NUM_TAPS);

    if (NUM_TAPS % DECIM != 0) begin : g_bad_length
        $error("NUM_TAPS must be a multiple of DECIM");
    end

    typedef struct packed {
        logic             vld;
        logic [OUT_W-1:0] dat;
    } out_st_t;

    out_st_t st_d, st_q;

    logic [DECIM-1:0]       load_sel;
    logic                   group_end;
    logic [DECIM*ACC_W-1:0] partials;
    logic [OUT_W-1:0]       summed;

    poly_commutator #(.DECIM(DECIM)) u_comm (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .load_sel  (load_sel),
        .group_end (group_end)
    );

    for (genvar k = 0; k < DECIM; k++) begin : g_branch
        logic [SUB_TAPS*COEF_W-1:0] branch_coefs;
        // Branch k takes taps k, k+DECIM, k+2*DECIM, ...
        for (genvar j = 0; j < SUB_TAPS; j++) begin : g_pick
            assign branch_coefs[j*COEF_W +: COEF_W] = COEFS[(k + j*DECIM)*COEF_W +: COEF_W];
        end
        poly_subfilter #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .TAPS   (SUB_TAPS),
            .ACC_W  (ACC_W)
        ) u_sub (
            .clk     (clk),
            .rst     (rst),
            .load    (load_sel[k]),
            .sample  (in_data),
            .coefs   (branch_coefs),
            .partial (partials[k*ACC_W +: ACC_W])
        );
    end

    poly_sum #(
        .NUM       (DECIM),
        .ACC_W     (ACC_W),
        .OUT_W     (OUT_W),
        .OUT_SHIFT (OUT_SHIFT)
    ) u_sum (
        .partials (partials),
        .result   (summed)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = group_end;
        if (group_end) begin
            st_d.dat = summed;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_data  = st_q.dat;

endmodule

// File: rtl/poly_decim_fir_chk.sv
module poly_decim_fir_chk #(
    parameter int DECIM = 4,
    parameter int OUT_W = 20
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             out_valid,
    input logic [OUT_W-1:0] out_data
);
    // Independent count of accepted samples within a group.
    logic [7:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q <= '0;
        end else if (in_valid) begin
            seen_q <= (int'(seen_q) == DECIM - 1) ? '0 : seen_q + 8'd1;
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        $fell(rst) |-> (!out_valid && out_data == '0));

    a_r2_group_pulse: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid && seen_q == '0 && !rst));

    a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    a_r4_idle_no_output: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

endmodule

bind poly_decim_fir poly_decim_fir_chk #(.DECIM(DECIM), .OUT_W(OUT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/poly_decim_fir_tb.sv
module poly_decim_fir_tb;
    localparam int OUT_W = 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             in_valid = 1'b0;
    logic [15:0]      in_data = '0;
    logic             out_valid;
    logic [OUT_W-1:0] out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    int h [16] = '{-120, -300, 150, 980, 2300, 3700, 4900, 5600,
                   5500, 4800, 3600, 2200, 900, 100, -250, -90};
    longint hist [1024];
    int t = 0;
    logic [OUT_W-1:0] last_out = '0;

    poly_decim_fir u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at time %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [OUT_W-1:0] model(input int tt);
        longint acc = 0;
        longint sh;
        for (int i = 0; i < 16; i++) begin
            if (tt - i >= 0) acc += longint'(h[i]) * hist[tt - i];
        end
        sh = acc >>> 15;
        return sh[OUT_W-1:0];
    endfunction

    // Called at a falling edge; returns at a falling edge with inputs idle.
    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t = 0;
        last_out = '0;
        check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
        check(out_data == '0, "R1 data", longint'(out_data), 0);
    endtask

    task automatic push(input int x, input int gap);
        logic [OUT_W-1:0] exp;
        in_valid = 1'b1;
        in_data  = 16'(x);
        hist[t]  = longint'(x);
        @(negedge clk);
        in_valid = 1'b0;
        if (t % 4 == 0) begin
            exp = model(t);
            check(out_valid == 1'b1, "R2 strobe", longint'(out_valid), 1);
            check(out_data == exp, "R3 value", longint'($signed(out_data)), longint'($signed(exp)));
            last_out = exp;
        end else begin
            check(out_valid == 1'b0, "R2 quiet", longint'(out_valid), 0);
            check(out_data == last_out, "R8 hold", longint'($signed(out_data)), longint'($signed(last_out)));
        end
        t++;
        for (int g = 0; g < gap; g++) begin
            in_data = 16'($urandom);
            @(negedge clk);
            check(out_valid == 1'b0 && out_data == last_out, "R4 idle",
                  longint'($signed(out_data)), longint'($signed(last_out)));
        end
    endtask

    task automatic test_floor();   // R6, R5
        push(1, 0);
        check(out_data == 20'hFFFFF, "R6 floor", longint'($signed(out_data)), -1);
        for (int i = 0; i < 15; i++) push(0, 0);
    endtask

    task automatic test_impulse(); // R3, R5
        push(16384, 0);
        for (int i = 0; i < 19; i++) push(0, 0);
    endtask

    task automatic test_step();    // R3
        for (int i = 0; i < 24; i++) push(10000, 0);
    endtask

    task automatic test_fullscale(); // R7
        for (int i = 0; i < 20; i++) push(-32768, 0);
        for (int i = 0; i < 20; i++) push(32767, 0);
        for (int i = 0; i < 20; i++) push((i % 2 == 0) ? -32768 : 32767, 0);
    endtask

    task automatic test_gaps();    // R4
        for (int i = 0; i < 40; i++) push(int'($signed(16'($urandom))), int'($urandom % 4));
    endtask

    task automatic test_random();  // R3
        for (int i = 0; i < 96; i++) push(int'($signed(16'($urandom))), 0);
    endtask

    task automatic test_midreset(); // R9
        for (int i = 0; i < 6; i++) push(30000 - i * 7000, 0);
        do_reset();
        push(16384, 0);
        check(out_data == model(0), "R9 restart", longint'($signed(out_data)), -60);
        for (int i = 0; i < 15; i++) push(0, 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        void'($urandom(7));
        @(negedge clk);
        do_reset();
        test_floor();
        do_reset();
        test_impulse();
        test_step();
        do_reset();
        test_fullscale();
        do_reset();
        test_gaps();
        test_random();
        test_midreset();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule